// File: doc/BRIEF.md
# Iterative Multiply and Divide Unit

This block is a small register-mapped arithmetic engine. Software writes operand bytes over a single-cycle write strobe with a 3-bit register select. Two of the selects start an operation. An unsigned 8×8 multiply runs for 8 clock cycles and an unsigned 16÷8 divide runs for 16 clock cycles. Both use one shared shift register and two 16-bit result registers.

The result registers are outputs at all times, so partial values are visible while an operation runs. One register holds the product or, for a divide, the remainder. The other holds the quotient; during a multiply it carries the operand bits being consumed. A start write always preloads the product/remainder register. When the unit is already busy, the write latches no operand and does not restart the operation.

Top module: `muldiv_unit`

## Requirements
- R1: After reset both result registers read 0 and `busy` is low. `busy` stays low until a start write is accepted.
- R2: A write to select 0 latches the multiplicand A. A write to select 1 while idle latches the multiplier B and starts a multiply. `busy` is high for exactly 8 cycles after that write edge. At the end the product equals A×B and the quotient reads B.
- R3: Selects 2 and 3 write the low and high dividend bytes. A write to select 4 while idle starts a divide by that byte. `busy` is high for exactly 16 cycles. At the end the quotient and remainder are the unsigned 16÷8 results.
- R4: Dividing by zero gives a quotient of 0xFFFF and a remainder equal to the dividend.
- R5: A multiply start loads the quotient with {B, A}. On iteration k (k = 1..8), B·2^(k-1) is added to the product when multiplicand bit k-1 is set, and the quotient shifts right by one bit. After k iterations the quotient reads {B, A} >> k.
- R6: Every write to select 1 sets the product register to 0 on that edge, whether or not the start is accepted.
- R7: Every write to select 4 copies the current 16-bit dividend into the product/remainder register on that edge, whether or not the start is accepted.
- R8: A start write while `busy` latches no operand and does not restart. The running operation ends at its original cycle. On the colliding edge the preload of R6/R7 wins over that iteration's update of the product/remainder register, and the remaining state still advances.
- R9: Multiplicand and dividend bytes are latched on any cycle, busy or not, and do not disturb a running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0..4) |
| wr_data | input | 8 | Write data byte |
| quotient | output | 16 | Quotient / multiply operand shifter |
| prod_rem | output | 16 | Product or remainder |
| busy | output | 1 | Operation in progress |

## Verification
The case that needs care is a start write that lands on an edge where an iteration is also running. The bench provokes it three ways: a second multiply start in the middle of a multiply, a divide start on the first cycle of a multiply, and a dividend write during a divide. It judges each collision by the product/remainder value one cycle later, by the cycle on which `busy` falls, and by the final results. The expected final results are worked out from the multiplicand bits that are still to be examined after the preload overwrote the partial sum.

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int OPW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  logic [OPW-1:0]       wr_data,
  output logic [2*OPW-1:0]     quotient,
  output logic [2*OPW-1:0]     prod_rem,
  output logic                 busy
);
  localparam int RW = 2 * OPW;
  localparam int SW = 3 * OPW;
  localparam int MUL_STEPS = OPW;
  localparam int DIV_STEPS = 2 * OPW;
  localparam int CW = $clog2(DIV_STEPS + 1);
  localparam logic [2:0] SEL_MCAND = 3'd0;
  localparam logic [2:0] SEL_MPLR  = 3'd1;
  localparam logic [2:0] SEL_DLO   = 3'd2;
  localparam logic [2:0] SEL_DHI   = 3'd3;
  localparam logic [2:0] SEL_DIVR  = 3'd4;

  logic [OPW-1:0] mcand;
  logic [RW-1:0]  dvd, quot, pr;
  logic [SW-1:0]  shf, shr;
  logic [CW-1:0]  cnt;
  logic           is_div, ge;

  assign busy     = (cnt != '0);
  assign quotient = quot;
  assign prod_rem = pr;
  assign shr      = shf >> 1;
  assign ge       = {{OPW{1'b0}}, pr} >= shr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand  <= '0;
      dvd    <= '0;
      quot   <= '0;
      pr     <= '0;
      shf    <= '0;
      cnt    <= '0;
      is_div <= 1'b0;
    end else begin
      if (busy) begin
        cnt <= cnt - 1'b1;
        if (!is_div) begin
          if (quot[0]) pr <= pr + shf[RW-1:0];
          quot <= quot >> 1;
          shf  <= shf << 1;
        end else begin
          quot <= {quot[RW-2:0], ge};
          shf  <= shr;
          if (ge) pr <= pr - shr[RW-1:0];
        end
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_MCAND: mcand <= wr_data;
          SEL_MPLR: begin
            pr <= '0;
            if (!busy) begin
              quot   <= {wr_data, mcand};
              shf    <= {{(SW-OPW){1'b0}}, wr_data};
              cnt    <= CW'(MUL_STEPS);
              is_div <= 1'b0;
            end
          end
          SEL_DLO: dvd[OPW-1:0] <= wr_data;
          SEL_DHI: dvd[RW-1:OPW] <= wr_data;
          SEL_DIVR: begin
            pr <= dvd;
            if (!busy) begin
              shf    <= {wr_data, {RW{1'b0}}};
              cnt    <= CW'(DIV_STEPS);
              is_div <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic mul_wr, div_wr;
  assign mul_wr = wr_en && (wr_sel == SEL_MPLR);
  assign div_wr = wr_en && (wr_sel == SEL_DIVR);

  a_r1_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !mul_wr && !div_wr) |=> !busy);
  a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (mul_wr || div_wr)) |=> busy);
  a_r6_mul_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mul_wr |=> (prod_rem == '0));
  a_r7_div_start_copies: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (prod_rem == $past(dvd)));
  a_r8_reject_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mul_wr || div_wr) && cnt == CW'(1)) |=> !busy);
endmodule

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [15:0] quotient, prod_rem;
  logic busy;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  muldiv_unit dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
                   .wr_data(wr_data), .quotient(quotient), .prod_rem(prod_rem), .busy(busy));

  // {is_div, a_or_dividend, b, expected prod/rem, expected quotient}
  localparam logic [56:0] VEC [0:8] = '{
    {1'b0, 16'h00FF, 8'hFF, 16'hFE01, 16'h00FF},
    {1'b0, 16'h0012, 8'h34, 16'h03A8, 16'h0034},
    {1'b0, 16'h0000, 8'h77, 16'h0000, 16'h0077},
    {1'b0, 16'h0080, 8'h02, 16'h0100, 16'h0002},
    {1'b1, 16'hFFFF, 8'hFF, 16'h0000, 16'h0101},
    {1'b1, 16'h03E8, 8'h07, 16'h0006, 16'h008E},
    {1'b1, 16'h1234, 8'h01, 16'h0000, 16'h1234},
    {1'b1, 16'h0005, 8'h09, 16'h0005, 16'h0000},
    {1'b1, 16'hABCD, 8'h00, 16'hABCD, 16'hFFFF}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset quotient", quotient, 16'h0000);
    chk("R1 reset prod_rem", prod_rem, 16'h0000);
    chk("R1 reset busy", {15'b0, busy}, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle busy", {15'b0, busy}, 16'h0000);

    for (int i = 0; i < 9; i++) begin
      logic [56:0] v;
      v = VEC[i];
      if (!v[56]) begin
        wr(3'd0, v[47:40]);
        wr(3'd1, v[39:32]);
        repeat (10) @(negedge clk);
        chk("R2 product", prod_rem, v[31:16]);
        chk("R2 quotient", quotient, v[15:0]);
      end else begin
        wr(3'd2, v[47:40]);
        wr(3'd3, v[55:48]);
        wr(3'd4, v[39:32]);
        repeat (18) @(negedge clk);
        chk(v[39:32] == 8'h00 ? "R4 remainder" : "R3 remainder", prod_rem, v[31:16]);
        chk(v[39:32] == 8'h00 ? "R4 quotient" : "R3 quotient", quotient, v[15:0]);
      end
    end

    // R2 busy length
    wr(3'd0, 8'h0B); wr(3'd1, 8'h0D);
    count_busy(n);
    chk("R2 busy cycles", 16'(n), 16'd8);
    chk("R2 product 0x0B*0x0D", prod_rem, 16'h008F);

    // R3/R4 busy length, divide by zero
    wr(3'd2, 8'h21); wr(3'd3, 8'h43); wr(3'd4, 8'h00);
    count_busy(n);
    chk("R3 busy cycles", 16'(n), 16'd16);
    chk("R4 div0 quotient", quotient, 16'hFFFF);
    chk("R4 div0 remainder", prod_rem, 16'h4321);

    // R5 intermediate, then R6/R8 collision
    wr(3'd0, 8'h83); wr(3'd1, 8'h05);
    chk("R5 preload quotient", quotient, 16'h0583);
    repeat (2) @(negedge clk);
    chk("R5 partial product after 2", prod_rem, 16'd15);
    chk("R5 quotient after 2", quotient, 16'h0160);
    wr(3'd1, 8'h07);
    chk("R6 cleared on rejected start", prod_rem, 16'h0000);
    chk("R8 still busy", {15'b0, busy}, 16'h0001);
    count_busy(n);
    chk("R8 original end cycle", 16'(n), 16'd5);
    chk("R8 product after collision", prod_rem, 16'd640);
    chk("R8 multiplier not relatched", quotient, 16'h0005);

    // R7 collision: divide start on first multiply cycle
    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    wr(3'd0, 8'h03); wr(3'd1, 8'h05);
    wr(3'd4, 8'h09);
    chk("R7 dividend copied", prod_rem, 16'h1234);
    count_busy(n);
    chk("R8 no divide restart", 16'(n), 16'd7);
    chk("R7 final product", prod_rem, 16'h123E);
    chk("R8 quotient from multiply", quotient, 16'h0005);

    // R9 dividend write during divide
    wr(3'd2, 8'hE8); wr(3'd3, 8'h03); wr(3'd4, 8'h07);
    wr(3'd2, 8'h00);
    count_busy(n);
    chk("R9 quotient undisturbed", quotient, 16'd142);
    chk("R9 remainder undisturbed", prod_rem, 16'd6);
    wr(3'd4, 8'h01);
    chk("R9 new dividend latched", prod_rem, 16'h0300);
    count_busy(n);
    chk("R9 divide by one", quotient, 16'h0300);

    finish_run();
  end
endmodule